// File: doc/BRIEF.md
# Mode and extended-mode register unit

This unit sits on the command side of a behavioural model of a low-power DDR SDRAM. On every rising clock edge it looks at the command strobes, the bank address and the row/column address. It recognises a register-programming command and steers the operand either into the main mode register or into the extended mode register. The stored fields are decoded and presented continuously: burst length, burst ordering, CAS latency, the portion of the array kept alive during self refresh, and output drive strength.

The unit also enforces the programming rules. A write is taken only while every bank is idle and outside the settle window of the previous write. Illegal bank-address selections, reserved field codes and set reserved bits are also refused. A refused write raises a one-cycle error pulse and leaves both registers as they were. A busy flag covers the settle window. Any accepted write to the main register also returns the extended register to its default contents.

Top module: `mrs_unit`

## Requirements
- R1: A register write is recognised only on a rising edge where cke_i is high and was also high at the previous edge, with cs_n_i, ras_n_i, cas_n_i and we_n_i all low. Any other combination changes no output.
- R2: ba_i = 2'b00 targets the main register and ba_i = 2'b10 targets the extended register. ba_i = 2'b01 or 2'b11 gives error_o and changes neither register.
- R3: In a main write, addr_i[2:0] sets burst_len_o: 3'b001 gives 2, 3'b010 gives 4, 3'b011 gives 8 and 3'b100 gives 16. Every other code is reserved.
- R4: In a main write, addr_i[3] sets burst_interleave_o (0 sequential, 1 interleaved). addr_i[6:4] sets cas_lat_o: 3'b010 gives 2 and 3'b011 gives 3. Every other code is reserved.
- R5: In an extended write, addr_i[2:0] sets refresh_area_o: 3'b000 gives 0 (whole array), 3'b001 gives 1 (half) and 3'b010 gives 2 (quarter); other codes are reserved. addr_i[6:5] sets drive_strength_o: 0 full, 1 half, 2 quarter, 3 eighth.
- R6: After reset, mode_valid_o, burst_len_o, burst_interleave_o, cas_lat_o, busy_o and error_o are 0. drive_strength_o is 1 (half) and refresh_area_o is 0 (whole array).
- R7: Every accepted main write returns drive_strength_o to 1 and refresh_area_o to 0.
- R8: busy_o is high for the single cycle after an accepted write. A write sampled while busy_o is high is refused with error_o. A write two edges after an accepted one is taken.
- R9: A write sampled while banks_idle_i is low is refused with error_o and changes neither register.
- R10: A write is refused with error_o and changes no field if it has a reserved code or a set reserved bit. The reserved bits are addr_i[12:7] for both registers, plus addr_i[4:3] for the extended register.
- R11: mode_valid_o rises with the first accepted main write and stays high until reset.
- R12: error_o is a one-cycle pulse in the cycle after a refused write. It never rises for an accepted write or for a non-write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Command clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cke_i | input | 1 | Clock enable |
| cs_n_i | input | 1 | Chip select, active low |
| ras_n_i | input | 1 | Row strobe, active low |
| cas_n_i | input | 1 | Column strobe, active low |
| we_n_i | input | 1 | Write strobe, active low |
| ba_i | input | 2 | Bank address, selects the target register |
| addr_i | input | 13 | Operand bits |
| banks_idle_i | input | 1 | High when every bank is precharged |
| burst_len_o | output | 5 | Burst length in beats (0 until valid) |
| burst_interleave_o | output | 1 | 1 = interleaved burst order |
| cas_lat_o | output | 2 | CAS latency in cycles (0 until valid) |
| mode_valid_o | output | 1 | Main register has been programmed |
| refresh_area_o | output | 2 | Self-refresh area: 0 full, 1 half, 2 quarter |
| drive_strength_o | output | 2 | Drive: 0 full, 1 half, 2 quarter, 3 eighth |
| busy_o | output | 1 | Settle window after an accepted write |
| error_o | output | 1 | Pulse after a refused write |

## Verification
Two functions can meet on one edge: the settle-window guard and the acceptance of a fully legal write. The bench provokes this by issuing a legal main write on the edge right after an accepted one. The second write must come back with error_o while every field keeps the first write's values. A third legal write on the following edge must then be taken with no error. The same pattern decides whether an accepted main write wipes the extended register in the same edge that it loads the main fields.

// File: rtl/mrs_pkg.sv
package mrs_pkg;

  localparam logic [1:0] BA_MAIN = 2'b00;
  localparam logic [1:0] BA_EXT  = 2'b10;

  typedef struct packed {
    logic [2:0] bl_code;
    logic       interleave;
    logic [2:0] cl_code;
  } main_fields_t;

  typedef struct packed {
    logic [2:0] area_code;
    logic [1:0] ds_code;
  } ext_fields_t;

  localparam main_fields_t MAIN_RESET = '{bl_code: 3'd0, interleave: 1'b0, cl_code: 3'd0};
  localparam ext_fields_t  EXT_DEFAULT = '{area_code: 3'd0, ds_code: 2'd1};

endpackage

// File: rtl/mrs_cmd_decode.sv
module mrs_cmd_decode
  import mrs_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cke_i,
  input  logic              cs_n_i,
  input  logic              ras_n_i,
  input  logic              cas_n_i,
  input  logic              we_n_i,
  input  logic [1:0]        ba_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              banks_idle_i,
  input  logic              busy_i,
  output logic              wr_main_o,
  output logic              wr_ext_o,
  output logic              wr_bad_o,
  output main_fields_t      main_o,
  output ext_fields_t       ext_o
);

  localparam int HI_LSB = 7;

  logic cke_q;
  logic cmd_hit;
  logic hi_zero, main_legal, ext_legal, gate_ok;
  logic tgt_main, tgt_ext;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cke_q <= 1'b0;
    else         cke_q <= cke_i;
  end

  assign cmd_hit = cke_q & cke_i & ~cs_n_i & ~ras_n_i & ~cas_n_i & ~we_n_i;

  assign main_o = '{bl_code: addr_i[2:0], interleave: addr_i[3], cl_code: addr_i[6:4]};
  assign ext_o  = '{area_code: addr_i[2:0], ds_code: addr_i[6:5]};

  assign hi_zero    = (addr_i[ADDR_W-1:HI_LSB] == '0);
  assign main_legal = hi_zero
                    && (main_o.bl_code >= 3'd1) && (main_o.bl_code <= 3'd4)
                    && ((main_o.cl_code == 3'd2) || (main_o.cl_code == 3'd3));
  assign ext_legal  = hi_zero && (addr_i[4:3] == 2'b00) && (ext_o.area_code <= 3'd2);

  assign tgt_main = (ba_i == BA_MAIN);
  assign tgt_ext  = (ba_i == BA_EXT);
  assign gate_ok  = banks_idle_i & ~busy_i;

  assign wr_main_o = cmd_hit & gate_ok & tgt_main & main_legal;
  assign wr_ext_o  = cmd_hit & gate_ok & tgt_ext  & ext_legal;
  assign wr_bad_o  = cmd_hit & ~wr_main_o & ~wr_ext_o;

  // every recognised write lands in exactly one outcome
  assert_one_outcome_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_hit |-> ($countones({wr_main_o, wr_ext_o, wr_bad_o}) == 1));

  assert_idle_gate_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !banks_idle_i |-> !(wr_main_o || wr_ext_o));

  assert_no_cmd_no_write_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_n_i || !cke_i) |-> !(wr_main_o || wr_ext_o || wr_bad_o));

endmodule

// File: rtl/mrs_main_reg.sv
module mrs_main_reg
  import mrs_pkg::*;
#(
  parameter int MAX_BL = 16
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_i,
  input  main_fields_t               fields_i,
  output logic [$clog2(MAX_BL+1)-1:0] burst_len_o,
  output logic                       burst_interleave_o,
  output logic [1:0]                 cas_lat_o,
  output logic                       valid_o
);

  localparam int BL_W = $clog2(MAX_BL + 1);

  main_fields_t q;
  logic         valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q       <= MAIN_RESET;
      valid_q <= 1'b0;
    end else if (wr_i) begin
      q       <= fields_i;
      valid_q <= 1'b1;
    end
  end

  assign valid_o            = valid_q;
  assign burst_len_o        = valid_q ? (BL_W'(1) << q.bl_code) : '0;
  assign burst_interleave_o = valid_q & q.interleave;
  assign cas_lat_o          = valid_q ? q.cl_code[1:0] : 2'd0;

  assert_valid_sticky_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(valid_o) |-> valid_o);

  assert_cl_legal_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (cas_lat_o == 2'd2 || cas_lat_o == 2'd3));

  assert_bl_onehot_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ($countones(burst_len_o) == 1 && burst_len_o >= 2));

endmodule

// File: rtl/mrs_ext_reg.sv
module mrs_ext_reg
  import mrs_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_main_i,
  input  logic        wr_ext_i,
  input  ext_fields_t fields_i,
  output logic [1:0]  refresh_area_o,
  output logic [1:0]  drive_strength_o
);

  ext_fields_t q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        q <= EXT_DEFAULT;
    else if (wr_main_i) q <= EXT_DEFAULT;
    else if (wr_ext_i)  q <= fields_i;
  end

  assign refresh_area_o   = q.area_code[1:0];
  assign drive_strength_o = q.ds_code;

  assert_area_legal_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refresh_area_o != 2'd3);

  assert_main_clears_ext_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_main_i |=> (drive_strength_o == 2'd1 && refresh_area_o == 2'd0));

endmodule

// File: rtl/mrs_unit.sv
module mrs_unit
  import mrs_pkg::*;
#(
  parameter int ADDR_W     = 13,
  parameter int MAX_BL     = 16,
  parameter int MRD_CYCLES = 2
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        cke_i,
  input  logic                        cs_n_i,
  input  logic                        ras_n_i,
  input  logic                        cas_n_i,
  input  logic                        we_n_i,
  input  logic [1:0]                  ba_i,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic                        banks_idle_i,
  output logic [$clog2(MAX_BL+1)-1:0] burst_len_o,
  output logic                        burst_interleave_o,
  output logic [1:0]                  cas_lat_o,
  output logic                        mode_valid_o,
  output logic [1:0]                  refresh_area_o,
  output logic [1:0]                  drive_strength_o,
  output logic                        busy_o,
  output logic                        error_o
);

  localparam int CNT_W = (MRD_CYCLES > 1) ? $clog2(MRD_CYCLES) : 1;
  localparam logic [CNT_W-1:0] HOLD = CNT_W'(MRD_CYCLES - 1);

  logic         wr_main, wr_ext, wr_bad;
  main_fields_t main_f;
  ext_fields_t  ext_f;
  logic [CNT_W-1:0] hold_cnt;
  logic         err_q;

  mrs_cmd_decode #(.ADDR_W(ADDR_W)) u_dec (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cke_i        (cke_i),
    .cs_n_i       (cs_n_i),
    .ras_n_i      (ras_n_i),
    .cas_n_i      (cas_n_i),
    .we_n_i       (we_n_i),
    .ba_i         (ba_i),
    .addr_i       (addr_i),
    .banks_idle_i (banks_idle_i),
    .busy_i       (busy_o),
    .wr_main_o    (wr_main),
    .wr_ext_o     (wr_ext),
    .wr_bad_o     (wr_bad),
    .main_o       (main_f),
    .ext_o        (ext_f)
  );

  mrs_main_reg #(.MAX_BL(MAX_BL)) u_main (
    .clk_i              (clk_i),
    .rst_ni             (rst_ni),
    .wr_i               (wr_main),
    .fields_i           (main_f),
    .burst_len_o        (burst_len_o),
    .burst_interleave_o (burst_interleave_o),
    .cas_lat_o          (cas_lat_o),
    .valid_o            (mode_valid_o)
  );

  mrs_ext_reg u_ext (
    .clk_i            (clk_i),
    .rst_ni           (rst_ni),
    .wr_main_i        (wr_main),
    .wr_ext_i         (wr_ext),
    .fields_i         (ext_f),
    .refresh_area_o   (refresh_area_o),
    .drive_strength_o (drive_strength_o)
  );

  // settle window: next write allowed MRD_CYCLES edges after an accepted one
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                hold_cnt <= '0;
    else if (wr_main || wr_ext) hold_cnt <= HOLD;
    else if (hold_cnt != '0)    hold_cnt <= hold_cnt - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= wr_bad;
  end

  assign busy_o  = (hold_cnt != '0);
  assign error_o = err_q;

  assert_busy_after_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_main || wr_ext) |=> busy_o);

  assert_err_keeps_main_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o |-> ($stable(burst_len_o) && $stable(cas_lat_o) && $stable(burst_interleave_o)));

  assert_err_keeps_ext_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o |-> ($stable(refresh_area_o) && $stable(drive_strength_o)));

  assert_err_pulse_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_main || wr_ext) |=> !error_o);

endmodule

// File: tb/mrs_unit_bench.sv
module mrs_unit_bench;

  localparam time CLK_P = 20ns;
  localparam int  WDOG  = 5000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0]  ba = 2'b00;
  logic [12:0] addr = '0;
  logic        idle = 1'b1;
  logic [4:0]  bl;
  logic        bt, valid, busy, err;
  logic [1:0]  cl, area, ds;

  int total = 0, bad = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  mrs_unit u_mrs_unit (
    .clk_i (clk), .rst_ni (rst_n), .cke_i (cke),
    .cs_n_i (cs_n), .ras_n_i (ras_n), .cas_n_i (cas_n), .we_n_i (we_n),
    .ba_i (ba), .addr_i (addr), .banks_idle_i (idle),
    .burst_len_o (bl), .burst_interleave_o (bt), .cas_lat_o (cl),
    .mode_valid_o (valid), .refresh_area_o (area), .drive_strength_o (ds),
    .busy_o (busy), .error_o (err)
  );

  // {addr[12:0], exp_err, exp_bl[4:0], exp_bt, exp_cl[1:0]}
  localparam int NV = 9;
  localparam logic [21:0] VEC [NV] = '{
    {13'h032, 1'b0, 5'd4,  1'b0, 2'd3},
    {13'h02B, 1'b0, 5'd8,  1'b1, 2'd2},
    {13'h03C, 1'b0, 5'd16, 1'b1, 2'd3},
    {13'h021, 1'b0, 5'd2,  1'b0, 2'd2},
    {13'h035, 1'b1, 5'd2,  1'b0, 2'd2},
    {13'h011, 1'b1, 5'd2,  1'b0, 2'd2},
    {13'h0A2, 1'b1, 5'd2,  1'b0, 2'd2},
    {13'h000, 1'b1, 5'd2,  1'b0, 2'd2},
    {13'h03A, 1'b0, 5'd4,  1'b1, 2'd3}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive at a negedge; returns at the next negedge with the result visible
  task automatic send(input logic [1:0] b, input logic [12:0] a);
    cs_n = 1'b0; ras_n = 1'b0; cas_n = 1'b0; we_n = 1'b0; ba = b; addr = a;
    @(negedge clk);
    cs_n = 1'b1; ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1; ba = 2'b00; addr = '0;
  endtask

  task automatic chk_main(input string req, input int ebl, input int ebt, input int ecl);
    check(bl == 5'(ebl), req, bl, ebl);
    check(bt == 1'(ebt), req, bt, ebt);
    check(cl == 2'(ecl), req, cl, ecl);
  endtask

  task automatic chk_ext(input string req, input int ea, input int eds);
    check(area == 2'(ea), req, area, ea);
    check(ds == 2'(eds), req, ds, eds);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R6 reset state
    check(valid == 1'b0, "R6", valid, 0);
    chk_main("R6", 0, 0, 0);
    chk_ext("R6", 0, 1);
    check(busy == 1'b0 && err == 1'b0, "R6", {busy, err}, 0);

    // vector walk over main-register codes (R3, R4, R10)
    for (int i = 0; i < NV; i++) begin
      send(2'b00, VEC[i][21:9]);
      check(err == VEC[i][8], VEC[i][8] ? "R10" : "R12", err, VEC[i][8]);
      chk_main(VEC[i][8] ? "R10" : "R3", VEC[i][7:3], VEC[i][2], VEC[i][1:0]);
      if (i == 0) check(valid == 1'b1, "R11", valid, 1);
      @(negedge clk);
    end
    check(valid == 1'b1, "R11", valid, 1);

    // extended register (R5) and its reserved codes (R10)
    send(2'b10, 13'h041);
    chk_ext("R5", 1, 2);
    chk_main("R5", 4, 1, 3);
    @(negedge clk);
    send(2'b10, 13'h062);
    chk_ext("R5", 2, 3);
    @(negedge clk);
    send(2'b10, 13'h003);
    check(err == 1'b1, "R10", err, 1);
    chk_ext("R10", 2, 3);
    @(negedge clk);
    send(2'b10, 13'h008);
    check(err == 1'b1, "R10", err, 1);
    chk_ext("R10", 2, 3);
    @(negedge clk);

    // R2 undefined bank selections
    send(2'b01, 13'h021);
    check(err == 1'b1, "R2", err, 1);
    chk_main("R2", 4, 1, 3);
    chk_ext("R2", 2, 3);
    @(negedge clk);
    send(2'b11, 13'h041);
    check(err == 1'b1, "R2", err, 1);
    chk_ext("R2", 2, 3);
    @(negedge clk);

    // R7 main write restores extended defaults
    send(2'b00, 13'h032);
    chk_main("R7", 4, 0, 3);
    chk_ext("R7", 0, 1);
    check(busy == 1'b1, "R8", busy, 1);
    @(negedge clk);
    check(err == 1'b0 && busy == 1'b0, "R12", {err, busy}, 0);

    // R9 banks not idle
    idle = 1'b0;
    send(2'b00, 13'h021);
    check(err == 1'b1, "R9", err, 1);
    chk_main("R9", 4, 0, 3);
    idle = 1'b1;
    @(negedge clk);

    // R8 write during settle window, then on the following edge
    send(2'b10, 13'h041);
    check(busy == 1'b1, "R8", busy, 1);
    send(2'b00, 13'h03C);
    check(err == 1'b1, "R8", err, 1);
    chk_main("R8", 4, 0, 3);
    chk_ext("R8", 1, 2);
    send(2'b00, 13'h02B);
    check(err == 1'b0, "R8", err, 1'b0);
    chk_main("R8", 8, 1, 2);
    chk_ext("R7", 0, 1);
    @(negedge clk);

    // R1 clock enable low at the previous edge, then low now
    cke = 1'b0;
    @(negedge clk);
    cke = 1'b1;
    send(2'b00, 13'h021);
    check(err == 1'b0, "R1", err, 0);
    chk_main("R1", 8, 1, 2);
    @(negedge clk);
    cke = 1'b0;
    send(2'b00, 13'h021);
    check(err == 1'b0 && busy == 1'b0, "R1", {err, busy}, 0);
    chk_main("R1", 8, 1, 2);
    cke = 1'b1;
    @(negedge clk);
    // R1 one strobe high: not a register write
    cs_n = 1'b0; ras_n = 1'b0; cas_n = 1'b1; we_n = 1'b0; addr = 13'h021;
    @(negedge clk);
    cs_n = 1'b1; ras_n = 1'b1; we_n = 1'b1; addr = '0;
    check(err == 1'b0, "R1", err, 0);
    chk_main("R1", 8, 1, 2);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int c = 0; c < WDOG; c++) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected=%0d", WDOG, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule